// File: doc/BRIEF.md
# Predicated Register File with Deferred-Fault Poison Tracking

This block holds the integer architectural state of a statically scheduled core: thirty-two 64-bit general registers, each with a poison flag, and a bank of sixty-four one-bit predicates. Every operation presented to the write side names a qualifying predicate through a 6-bit index. If that predicate is false, the operation is dropped and changes nothing.

A speculative load that faults does not trap. It marks its destination as poisoned, and the fault is deferred. A copy passes a poisoned value on quietly. An ALU result or a predicate update that reads a poisoned source is refused instead. It then reports an exception that names the offending source register.

Operations arrive on a single valid-qualified port. The block accepts one operation on every cycle in which `op_valid` is high and never applies back-pressure, so the port has no ready signal. Two register read ports and one predicate read port are combinational and show the state that the last clock edge committed.

Top module: `pred_regfile`

## Requirements
- R1: A predicate-write operation (`op_cls` = 3) whose qualifying predicate is true stores `op_pval` into predicate `op_pdst`; `op_qp` (6 bits) selects the qualifying predicate out of 64, and `prd_val` shows predicate `prd_addr` from the next cycle on.
- R2: Predicate 0 always reads 1, and a predicate write aimed at it has no effect.
- R3: When the predicate selected by `op_qp` is 0, the operation changes no register, poison flag or predicate, and raises no exception even if its sources are poisoned.
- R4: An ALU operation (`op_cls` = 1) with clean sources writes `op_data` to `op_dst` and clears that register's poison flag; the new value is on the read ports in the cycle after the accepting edge.
- R5: A speculative load (`op_cls` = 2) with `op_fault` high sets the destination's poison flag and zeroes its value without raising an exception; with `op_fault` low it writes `op_data` and clears the poison flag.
- R6: A copy (`op_cls` = 0) moves the value and the poison flag of `op_src1` to `op_dst` and never raises an exception.
- R7: An ALU or predicate-write operation whose `op_src1` or `op_src2` is poisoned raises `exc_valid` for one cycle, in the cycle after the accepting edge, with `exc_reg` equal to `op_src1` if that source is poisoned and otherwise `op_src2`; the operation writes nothing.
- R8: Register 0 reads as zero with a clear poison flag, whatever is written to it.
- R9: After reset all registers are zero, all poison flags are clear, and every predicate except predicate 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_cls | input | 2 | 0 copy, 1 ALU, 2 speculative load, 3 predicate write |
| op_qp | input | 6 | Qualifying predicate index |
| op_src1 | input | 5 | First source register |
| op_src2 | input | 5 | Second source register |
| op_dst | input | 5 | Destination register |
| op_pdst | input | 6 | Destination predicate |
| op_pval | input | 1 | Value for a predicate write |
| op_data | input | 64 | ALU result or load data |
| op_fault | input | 1 | Load faulted |
| exc_valid | output | 1 | Exception pulse |
| exc_reg | output | 5 | Poisoned source that caused the exception |
| rd_a_addr | input | 5 | Read port A index |
| rd_a_data | output | 64 | Read port A value |
| rd_a_nat | output | 1 | Read port A poison flag |
| rd_b_addr | input | 5 | Read port B index |
| rd_b_data | output | 64 | Read port B value |
| rd_b_nat | output | 1 | Read port B poison flag |
| prd_addr | input | 6 | Predicate read index |
| prd_val | output | 1 | Predicate read value |

## Verification
State changes are due one edge after acceptance. The bench drives an operation, lets one rising edge pass, and samples the read ports at the following falling edge, so it never reads a value in the cycle it is being written. The exception pulse is registered and falls in the cycle after the accepting edge. The driver queues the expected pulse, or its absence, after that edge, and the monitor pops the entry at the next falling edge. This holds when operations run back to back, and any pulse that arrives while the queue is empty counts as a mismatch.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    OP_COPY  = 2'd0,
    OP_ALU   = 2'd1,
    OP_SLOAD = 2'd2,
    OP_PSET  = 2'd3
  } op_cls_e;
endpackage

// File: rtl/prf_pred_bank.sv
module prf_pred_bank #(
  parameter int NPRED = 64,
  localparam int PW = $clog2(NPRED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] qp_idx,
  output logic          qp_val,
  input  logic [PW-1:0] rd_idx,
  output logic          rd_val,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic          wval
);
  logic [NPRED-1:0] bits;

  assign bits[0] = 1'b1;

  for (genvar g = 1; g < NPRED; g++) begin : g_pred
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else if (we && widx == PW'(g)) q <= wval;
    end
    assign bits[g] = q;
  end

  assign qp_val = bits[qp_idx];
  assign rd_val = bits[rd_idx];

  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !we |=> $stable(bits)); // R3
endmodule

// File: rtl/prf_gpr_bank.sv
module prf_gpr_bank #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  output logic            ra_nat,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  output logic            rb_nat,
  input  logic [AW-1:0]   s1_addr,
  output logic [XLEN-1:0] s1_data,
  output logic            s1_nat,
  input  logic [AW-1:0]   s2_addr,
  output logic            s2_nat,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic            wnat
);
  logic [XLEN-1:0] val_w [NREG];
  logic [NREG-1:0] nat_w;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign val_w[g] = '0;
      assign nat_w[g] = 1'b0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      logic            n;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
          n <= 1'b0;
        end else if (we && waddr == AW'(g)) begin
          q <= wdata;
          n <= wnat;
        end
      end
      assign val_w[g] = q;
      assign nat_w[g] = n;
    end
  end

  assign ra_data = val_w[ra_addr];
  assign ra_nat  = nat_w[ra_addr];
  assign rb_data = val_w[rb_addr];
  assign rb_nat  = nat_w[rb_addr];
  assign s1_data = val_w[s1_addr];
  assign s1_nat  = nat_w[s1_addr];
  assign s2_nat  = nat_w[s2_addr];

  AST_NAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !we |=> $stable(nat_w)); // R3
  AST_FAULT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wnat && waddr != '0) |=> nat_w[$past(waddr)]); // R5
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  op_cls_e         op_cls,
  input  logic            qp_val,
  input  logic [AW-1:0]   src1,
  input  logic [AW-1:0]   src2,
  input  logic [AW-1:0]   dst,
  input  logic [XLEN-1:0] data,
  input  logic            fault,
  input  logic [XLEN-1:0] s1_data,
  input  logic            s1_nat,
  input  logic            s2_nat,
  output logic            gpr_we,
  output logic [AW-1:0]   gpr_waddr,
  output logic [XLEN-1:0] gpr_wdata,
  output logic            gpr_wnat,
  output logic            pr_we,
  output logic            exc_valid,
  output logic [AW-1:0]   exc_reg
);
  logic fire, consumes, bad;

  assign fire     = op_valid && qp_val;
  assign consumes = (op_cls == OP_ALU) || (op_cls == OP_PSET);
  assign bad      = consumes && (s1_nat || s2_nat);

  assign gpr_we    = fire && !bad && (op_cls != OP_PSET) && (dst != '0);
  assign gpr_waddr = dst;
  assign pr_we     = fire && !bad && (op_cls == OP_PSET);

  always_comb begin
    gpr_wdata = data;
    gpr_wnat  = 1'b0;
    unique case (op_cls)
      OP_COPY: begin
        gpr_wdata = s1_data;
        gpr_wnat  = s1_nat;
      end
      OP_SLOAD: begin
        gpr_wdata = fault ? '0 : data;
        gpr_wnat  = fault;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_reg   <= '0;
    end else begin
      exc_valid <= fire && bad;
      exc_reg   <= s1_nat ? src1 : src2;
    end
  end

  AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(op_valid && qp_val)); // R7
  AST_NO_EXC_FALSE_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !qp_val) |=> !exc_valid); // R3
  AST_COPY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_cls == OP_COPY) |=> !exc_valid); // R6
endmodule

// File: rtl/pred_regfile.sv
module pred_regfile
  import prf_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREG  = 32,
  parameter int NPRED = 64,
  localparam int AW = $clog2(NREG),
  localparam int PW = $clog2(NPRED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_cls,
  input  logic [PW-1:0]   op_qp,
  input  logic [AW-1:0]   op_src1,
  input  logic [AW-1:0]   op_src2,
  input  logic [AW-1:0]   op_dst,
  input  logic [PW-1:0]   op_pdst,
  input  logic            op_pval,
  input  logic [XLEN-1:0] op_data,
  input  logic            op_fault,
  output logic            exc_valid,
  output logic [AW-1:0]   exc_reg,
  input  logic [AW-1:0]   rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  output logic            rd_a_nat,
  input  logic [AW-1:0]   rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  output logic            rd_b_nat,
  input  logic [PW-1:0]   prd_addr,
  output logic            prd_val
);
  logic            qp_val;
  logic [XLEN-1:0] s1_data;
  logic            s1_nat, s2_nat;
  logic            gpr_we, gpr_wnat, pr_we;
  logic [AW-1:0]   gpr_waddr;
  logic [XLEN-1:0] gpr_wdata;

  prf_pred_bank #(.NPRED(NPRED)) u_pred (
    .clk(clk), .rst_n(rst_n),
    .qp_idx(op_qp), .qp_val(qp_val),
    .rd_idx(prd_addr), .rd_val(prd_val),
    .we(pr_we), .widx(op_pdst), .wval(op_pval)
  );

  prf_gpr_bank #(.XLEN(XLEN), .NREG(NREG)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(rd_a_addr), .ra_data(rd_a_data), .ra_nat(rd_a_nat),
    .rb_addr(rd_b_addr), .rb_data(rd_b_data), .rb_nat(rd_b_nat),
    .s1_addr(op_src1), .s1_data(s1_data), .s1_nat(s1_nat),
    .s2_addr(op_src2), .s2_nat(s2_nat),
    .we(gpr_we), .waddr(gpr_waddr), .wdata(gpr_wdata), .wnat(gpr_wnat)
  );

  prf_ctrl #(.XLEN(XLEN), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_cls(op_cls_e'(op_cls)), .qp_val(qp_val),
    .src1(op_src1), .src2(op_src2), .dst(op_dst),
    .data(op_data), .fault(op_fault),
    .s1_data(s1_data), .s1_nat(s1_nat), .s2_nat(s2_nat),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata), .gpr_wnat(gpr_wnat),
    .pr_we(pr_we), .exc_valid(exc_valid), .exc_reg(exc_reg)
  );

  AST_R0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0 && !rd_a_nat)); // R8
  AST_P0_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_addr == '0) |-> prd_val); // R2
endmodule

// File: tb/pred_regfile_test.sv
`timescale 1ns/1ps
module pred_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_cls = '0;
  logic [5:0]  op_qp = '0, op_pdst = '0, prd_addr = '0;
  logic [4:0]  op_src1 = '0, op_src2 = '0, op_dst = '0, rd_a_addr = '0, rd_b_addr = '0;
  logic        op_pval = 1'b0, op_fault = 1'b0;
  logic [63:0] op_data = '0;
  logic        exc_valid, rd_a_nat, rd_b_nat, prd_val;
  logic [4:0]  exc_reg;
  logic [63:0] rd_a_data, rd_b_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [63:0] m_reg [32];
  logic        m_nat [32];
  logic        m_pred [64];

  typedef struct { bit v; logic [4:0] r; string tag; } exc_t;
  exc_t exp_q [$];

  pred_regfile uut (.*);

  always #2.5 clk = ~clk;

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      report();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0) begin
        exc_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (exc_valid !== e.v || (e.v && exc_reg !== e.r)) begin
          n_bad++;
          $display("FAIL %s exception: actual v=%0b r=%0d expected v=%0b r=%0d",
                   e.tag, exc_valid, exc_reg, e.v, e.r);
        end
      end else if (exc_valid) begin
        n_chk++;
        n_bad++;
        $display("FAIL R7 spurious exception: actual v=1 r=%0d expected v=0", exc_reg);
      end
    end
  end

  task automatic do_op(input logic [1:0] cls, input logic [5:0] qp, input logic [4:0] s1,
                       input logic [4:0] s2, input logic [4:0] d, input logic [5:0] pd,
                       input logic pv, input logic [63:0] dat, input logic flt, input string tag);
    exc_t e;
    logic qv;
    op_cls = cls; op_qp = qp; op_src1 = s1; op_src2 = s2; op_dst = d;
    op_pdst = pd; op_pval = pv; op_data = dat; op_fault = flt; op_valid = 1'b1;
    @(posedge clk);
    e.v = 1'b0; e.r = '0; e.tag = tag;
    qv = m_pred[qp];
    if (qv) begin
      case (cls)
        2'd0: if (d != 0) begin m_reg[d] = m_reg[s1]; m_nat[d] = m_nat[s1]; end
        2'd2: if (d != 0) begin m_reg[d] = flt ? 64'd0 : dat; m_nat[d] = flt; end
        default: begin
          if (m_nat[s1]) begin e.v = 1'b1; e.r = s1; end
          else if (m_nat[s2]) begin e.v = 1'b1; e.r = s2; end
          else if (cls == 2'd1) begin
            if (d != 0) begin m_reg[d] = dat; m_nat[d] = 1'b0; end
          end else if (pd != 0) m_pred[pd] = pv;
        end
      endcase
    end
    exp_q.push_back(e);
    #1;
  endtask

  task automatic idle;
    op_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_reg(input logic [4:0] a, input string tag);
    rd_a_addr = a; rd_b_addr = a;
    #1;
    n_chk++;
    if (rd_a_data !== m_reg[a] || rd_a_nat !== m_nat[a] ||
        rd_b_data !== m_reg[a] || rd_b_nat !== m_nat[a]) begin
      n_bad++;
      $display("FAIL %s r%0d: actual a=%h/%0b b=%h/%0b expected %h/%0b", tag, a,
               rd_a_data, rd_a_nat, rd_b_data, rd_b_nat, m_reg[a], m_nat[a]);
    end
  endtask

  task automatic check_pred(input logic [5:0] p, input string tag);
    prd_addr = p;
    #1;
    n_chk++;
    if (prd_val !== m_pred[p]) begin
      n_bad++;
      $display("FAIL %s p%0d: actual %0b expected %0b", tag, p, prd_val, m_pred[p]);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin m_reg[i] = '0; m_nat[i] = 1'b0; end
    for (int i = 0; i < 64; i++) m_pred[i] = (i == 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    for (int i = 0; i < 32; i += 7) check_reg(5'(i), "R9");
    check_pred(6'd0, "R9"); check_pred(6'd63, "R9");

    // R1 predicate write through the 6-bit index
    do_op(2'd3, 6'd0, 5'd0, 5'd0, 5'd0, 6'd5, 1'b1, '0, 1'b0, "R1"); idle();
    check_pred(6'd5, "R1");
    do_op(2'd3, 6'd5, 5'd0, 5'd0, 5'd0, 6'd63, 1'b1, '0, 1'b0, "R1"); idle();
    check_pred(6'd63, "R1");

    // R2 predicate 0 ignores writes
    do_op(2'd3, 6'd0, 5'd0, 5'd0, 5'd0, 6'd0, 1'b0, '0, 1'b0, "R2"); idle();
    check_pred(6'd0, "R2");

    // R4 ALU write
    do_op(2'd1, 6'd0, 5'd0, 5'd0, 5'd1, 6'd0, 1'b0, 64'hDEAD_BEEF_0123_4567, 1'b0, "R4"); idle();
    check_reg(5'd1, "R4");

    // R3 false predicate leaves register untouched
    do_op(2'd1, 6'd6, 5'd0, 5'd0, 5'd1, 6'd0, 1'b0, 64'h1111, 1'b0, "R3"); idle();
    check_reg(5'd1, "R3");

    // R5 faulting speculative load
    do_op(2'd2, 6'd5, 5'd0, 5'd0, 5'd3, 6'd0, 1'b0, 64'h5555, 1'b1, "R5"); idle();
    check_reg(5'd3, "R5");

    // R6 copy carries poison, no exception
    do_op(2'd0, 6'd0, 5'd3, 5'd0, 5'd4, 6'd0, 1'b0, '0, 1'b0, "R6"); idle();
    check_reg(5'd4, "R6");
    do_op(2'd0, 6'd0, 5'd1, 5'd0, 5'd6, 6'd0, 1'b0, '0, 1'b0, "R6"); idle();
    check_reg(5'd6, "R6");

    // R7 poisoned src1 and src2, back to back
    do_op(2'd1, 6'd0, 5'd4, 5'd3, 5'd5, 6'd0, 1'b0, 64'h77, 1'b0, "R7");
    do_op(2'd1, 6'd0, 5'd1, 5'd3, 5'd5, 6'd0, 1'b0, 64'h78, 1'b0, "R7"); idle();
    check_reg(5'd5, "R7");
    do_op(2'd3, 6'd0, 5'd0, 5'd4, 5'd0, 6'd7, 1'b1, '0, 1'b0, "R7"); idle();
    check_pred(6'd7, "R7");

    // R3 false predicate with poisoned source: no exception
    do_op(2'd1, 6'd6, 5'd4, 5'd3, 5'd5, 6'd0, 1'b0, 64'h99, 1'b0, "R3"); idle();
    check_reg(5'd5, "R3");

    // R5 successful load clears poison
    do_op(2'd2, 6'd0, 5'd0, 5'd0, 5'd3, 6'd0, 1'b0, 64'hABCD, 1'b0, "R5"); idle();
    check_reg(5'd3, "R5");

    // R8 register 0 stays clean
    do_op(2'd1, 6'd0, 5'd0, 5'd0, 5'd0, 6'd0, 1'b0, 64'hFFFF, 1'b0, "R8"); idle();
    check_reg(5'd0, "R8");
    do_op(2'd2, 6'd0, 5'd0, 5'd0, 5'd0, 6'd0, 1'b0, '0, 1'b1, "R8"); idle();
    check_reg(5'd0, "R8");

    idle(); idle();
    finished = 1;
    report();
    $finish;
  end
endmodule